// File: doc/BRIEF.md
# Shared-RAM Multi-Queue Slot Pointer Store

This block keeps sixteen independent first-in first-out queues of scratchpad slot pointers, all stored in one shared synchronous RAM. A receiving thread's queue is picked by a queue index on each port. One enqueue and one dequeue can be issued in every cycle, each to any queue, including the same one. A small register table holds a read and a write position for every queue. Per-queue empty and full flags are derived from that table.

Each queue owns a fixed, equal region of `DEPTH` entries in the data RAM. An entry's RAM address is the queue index followed by the local position within the region. Positions carry one extra wrap bit so that a full queue and an empty queue can be told apart. `DEPTH` must be a power of two.

An enqueue to a full queue is refused through `enq_ok`, so that the producer can hold off. A dequeue returns its pointer one cycle after the request. Four instances of the block serve a 64-thread tile: thread id bits [5:4] select the instance and bits [3:0] select the queue.

Top module: `mq_ptr_store`

## Requirements
- R1: While reset is held, and after it is released, every queue is empty (`q_empty` all ones, `q_full` all zeros), and `deq_rvalid` and `deq_err` are low.
- R2: Pointers leave each queue in the order they were accepted, including after the local position wraps past the end of the queue's region.
- R3: Operations on one queue do not change the contents or the flags of any other queue; the lowest queue (0) and the highest queue (NQ-1) behave like any other.
- R4: `enq_ok` equals `enq_valid` AND NOT the full flag of the addressed queue, taken before this cycle's update. A refused enqueue stores nothing.
- R5: A queue's full flag rises after exactly `DEPTH` net accepted enqueues. Its empty flag rises when the queue is drained. Both flags are never high at once.
- R6: A dequeue to a non-empty queue raises `deq_rvalid` in the next cycle, with the head pointer on `deq_ptr`.
- R7: A dequeue to an empty queue is ignored. In the next cycle `deq_err` is high, `deq_rvalid` is low, and the queue's state is unchanged.
- R8: An accepted enqueue and an accepted dequeue to the same queue in one cycle leave that queue's occupancy unchanged and both take effect.
- R9: On a full queue, a same-cycle enqueue and dequeue refuse the enqueue and perform the dequeue.
- R10: On an empty queue, a same-cycle enqueue and dequeue accept the enqueue and treat the dequeue as an empty dequeue (R7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enq_valid | input | 1 | Enqueue request |
| enq_qid | input | QW | Queue addressed by the enqueue |
| enq_ptr | input | PTR_W | Slot pointer to store |
| enq_ok | output | 1 | Enqueue accepted this cycle (low means refused: hold off) |
| deq_valid | input | 1 | Dequeue request |
| deq_qid | input | QW | Queue addressed by the dequeue |
| deq_rvalid | output | 1 | Dequeued pointer valid (one cycle after the request) |
| deq_ptr | output | PTR_W | Dequeued slot pointer |
| deq_err | output | 1 | Previous-cycle dequeue hit an empty queue |
| q_empty | output | NQ | Per-queue empty flags |
| q_full | output | NQ | Per-queue full flags |

## Verification
The hardest situations to reach from the ports are the same-cycle collisions. These are an enqueue and a dequeue on one queue while that queue is full, while it is empty, and while it holds data with its local positions already wrapped. The stimulus table drives one queue through more than `DEPTH` pointers, so its positions cross the region boundary. It then places the combined requests exactly at the fill level where each rule applies. Directed tests fill a second queue, confirm that a refused pointer never appears when the queue is drained, and check that a reset taken mid-run clears queues that hold data.

// File: rtl/mq_pkg.sv
package mq_pkg;
  localparam int unsigned MQ_NQ    = 16;
  localparam int unsigned MQ_DEPTH = 4;
  localparam int unsigned MQ_PTR_W = 8;

  // full when the low position bits match and the wrap bits differ
  function automatic logic pos_full(input logic [31:0] rd, input logic [31:0] wr,
                                    input int unsigned lw);
    logic [31:0] lo_mask;
    lo_mask = (32'd1 << lw) - 32'd1;
    return ((rd & lo_mask) == (wr & lo_mask)) && (rd[lw] != wr[lw]);
  endfunction
endpackage

// File: rtl/mq_rst_sync.sv
module mq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/mq_ram.sv
module mq_ram #(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int unsigned WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/mq_meta.sv
module mq_meta #(
  parameter int unsigned NQ    = 16,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned QW   = $clog2(NQ),
  localparam int unsigned LW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enq_valid,
  input  logic [QW-1:0] enq_qid,
  input  logic          deq_valid,
  input  logic [QW-1:0] deq_qid,
  output logic          enq_fire,
  output logic          deq_fire,
  output logic [LW-1:0] wr_loc,
  output logic [LW-1:0] rd_loc,
  output logic [NQ-1:0] q_empty,
  output logic [NQ-1:0] q_full
);
  logic [LW:0] front_q [NQ];
  logic [LW:0] back_q  [NQ];
  logic [LW:0] front_d [NQ];
  logic [LW:0] back_d  [NQ];

  for (genvar gi = 0; gi < NQ; gi++) begin : g_flag
    assign q_empty[gi] = (front_q[gi] == back_q[gi]);
    assign q_full[gi]  = mq_pkg::pos_full(32'(front_q[gi]), 32'(back_q[gi]), LW);
  end

  assign enq_fire = enq_valid & ~q_full[enq_qid];
  assign deq_fire = deq_valid & ~q_empty[deq_qid];
  assign wr_loc   = back_q[enq_qid][LW-1:0];
  assign rd_loc   = front_q[deq_qid][LW-1:0];

  always_comb begin
    for (int i = 0; i < NQ; i++) begin
      front_d[i] = front_q[i];
      back_d[i]  = back_q[i];
    end
    if (enq_fire) back_d[enq_qid]  = back_q[enq_qid] + 1'b1;
    if (deq_fire) front_d[deq_qid] = front_q[deq_qid] + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NQ; i++) begin
        front_q[i] <= '0;
        back_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NQ; i++) begin
        if (enq_fire || deq_fire) begin
          front_q[i] <= front_d[i];
          back_q[i]  <= back_d[i];
        end
      end
    end
  end

  // R5: a queue never reports empty and full together
  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (q_empty & q_full) == '0);

  // R4: a refused enqueue (no same-queue dequeue) leaves the queue full
  a_r4_refused_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid && q_full[enq_qid] && !(deq_fire && deq_qid == enq_qid))
    |=> q_full[$past(enq_qid)]);

  // R8: combined enqueue and dequeue on one queue keep its flags
  a_r8_same_queue_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_fire && deq_fire && enq_qid == deq_qid)
    |=> (q_empty[$past(enq_qid)] == $past(q_empty[enq_qid]))
        && (q_full[$past(enq_qid)] == $past(q_full[enq_qid])));

  // R7: an empty dequeue alone leaves the queue empty
  a_r7_empty_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_valid && q_empty[deq_qid] && !(enq_fire && enq_qid == deq_qid))
    |=> q_empty[$past(deq_qid)]);
endmodule

// File: rtl/mq_ptr_store.sv
module mq_ptr_store #(
  parameter int unsigned NQ    = mq_pkg::MQ_NQ,
  parameter int unsigned DEPTH = mq_pkg::MQ_DEPTH,
  parameter int unsigned PTR_W = mq_pkg::MQ_PTR_W,
  localparam int unsigned QW   = $clog2(NQ),
  localparam int unsigned LW   = $clog2(DEPTH),
  localparam int unsigned AW   = QW + LW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enq_valid,
  input  logic [QW-1:0]    enq_qid,
  input  logic [PTR_W-1:0] enq_ptr,
  output logic             enq_ok,
  input  logic             deq_valid,
  input  logic [QW-1:0]    deq_qid,
  output logic             deq_rvalid,
  output logic [PTR_W-1:0] deq_ptr,
  output logic             deq_err,
  output logic [NQ-1:0]    q_empty,
  output logic [NQ-1:0]    q_full
);
  logic          rst_sync_n;
  logic          enq_fire;
  logic          deq_fire;
  logic [LW-1:0] wr_loc;
  logic [LW-1:0] rd_loc;
  logic          rvalid_d;
  logic          err_d;

  mq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mq_meta #(.NQ(NQ), .DEPTH(DEPTH)) u_meta (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .enq_valid (enq_valid),
    .enq_qid   (enq_qid),
    .deq_valid (deq_valid),
    .deq_qid   (deq_qid),
    .enq_fire  (enq_fire),
    .deq_fire  (deq_fire),
    .wr_loc    (wr_loc),
    .rd_loc    (rd_loc),
    .q_empty   (q_empty),
    .q_full    (q_full)
  );

  mq_ram #(.AW(AW), .DW(PTR_W)) u_ram (
    .clk     (clk),
    .wr_en   (enq_fire),
    .wr_addr ({enq_qid, wr_loc}),
    .wr_data (enq_ptr),
    .rd_en   (deq_fire),
    .rd_addr ({deq_qid, rd_loc}),
    .rd_data (deq_ptr)
  );

  assign enq_ok = enq_fire;

  always_comb begin
    rvalid_d = deq_fire;
    err_d    = deq_valid & ~deq_fire;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      deq_rvalid <= 1'b0;
      deq_err    <= 1'b0;
    end else begin
      deq_rvalid <= rvalid_d;
      deq_err    <= err_d;
    end
  end

  // R6: an accepted dequeue yields a valid pointer next cycle
  a_r6_rvalid_next: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (deq_valid && !q_empty[deq_qid]) |=> (deq_rvalid && !deq_err));

  // R7: a dequeue on an empty queue flags an error and returns nothing
  a_r7_err_next: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (deq_valid && q_empty[deq_qid]) |=> (deq_err && !deq_rvalid));

  // R4: no enqueue is accepted into a full queue
  a_r4_no_accept_full: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (enq_valid && q_full[enq_qid]) |-> !enq_ok);
endmodule

// File: tb/mq_ptr_store_bench.sv
module mq_ptr_store_bench;
  localparam int unsigned NQ = 16;
  localparam int unsigned DEPTH = 4;
  localparam int unsigned PW = 8;
  localparam int unsigned NV = 20;

  logic          clk;
  logic          rst_n;
  logic          enq_valid;
  logic [3:0]    enq_qid;
  logic [PW-1:0] enq_ptr;
  logic          enq_ok;
  logic          deq_valid;
  logic [3:0]    deq_qid;
  logic          deq_rvalid;
  logic [PW-1:0] deq_ptr;
  logic          deq_err;
  logic [NQ-1:0] q_empty;
  logic [NQ-1:0] q_full;

  int total;
  int bad;
  bit done;

  mq_ptr_store #(.NQ(NQ), .DEPTH(DEPTH), .PTR_W(PW)) u_mq_ptr_store (
    .clk(clk), .rst_n(rst_n),
    .enq_valid(enq_valid), .enq_qid(enq_qid), .enq_ptr(enq_ptr), .enq_ok(enq_ok),
    .deq_valid(deq_valid), .deq_qid(deq_qid),
    .deq_rvalid(deq_rvalid), .deq_ptr(deq_ptr), .deq_err(deq_err),
    .q_empty(q_empty), .q_full(q_full)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // vector: {ev, eq[3:0], ed[7:0], dv, dq[3:0], xok, xrv, xrd[7:0], xerr}
  function automatic logic [28:0] tv(input bit ev, input logic [3:0] eq, input logic [7:0] ed,
                                     input bit dv, input logic [3:0] dq, input bit xok,
                                     input bit xrv, input logic [7:0] xrd, input bit xerr);
    return {ev, eq, ed, dv, dq, xok, xrv, xrd, xerr};
  endfunction

  localparam logic [28:0] VEC [NV] = '{
    tv(1, 2, 8'hA1, 0, 0, 1, 0, 8'h00, 0), // R2 fill q2
    tv(1, 2, 8'hA2, 0, 0, 1, 0, 8'h00, 0),
    tv(1, 5, 8'hB1, 0, 0, 1, 0, 8'h00, 0), // R3 second queue
    tv(0, 0, 8'h00, 1, 2, 0, 1, 8'hA1, 0), // R6 read latency
    tv(1, 2, 8'hA3, 1, 5, 1, 1, 8'hB1, 0), // R3 parallel ops, different queues
    tv(0, 0, 8'h00, 1, 5, 0, 0, 8'h00, 1), // R7 q5 now empty
    tv(1, 2, 8'hA4, 1, 2, 1, 1, 8'hA2, 0), // R8 same queue, partially filled
    tv(1, 2, 8'hA5, 0, 0, 1, 0, 8'h00, 0),
    tv(1, 2, 8'hA6, 0, 0, 1, 0, 8'h00, 0), // R5 q2 reaches DEPTH
    tv(1, 2, 8'hA7, 0, 0, 0, 0, 8'h00, 0), // R4 refused
    tv(1, 2, 8'hA8, 1, 2, 0, 1, 8'hA3, 0), // R9 full: enq refused, deq done
    tv(0, 0, 8'h00, 1, 2, 0, 1, 8'hA4, 0), // R2 wrapped positions
    tv(0, 0, 8'h00, 1, 2, 0, 1, 8'hA5, 0),
    tv(0, 0, 8'h00, 1, 2, 0, 1, 8'hA6, 0),
    tv(0, 0, 8'h00, 1, 2, 0, 0, 8'h00, 1), // R7 drained
    tv(1, 9, 8'hC1, 1, 9, 1, 0, 8'h00, 1), // R10 empty: enq ok, deq err
    tv(0, 0, 8'h00, 1, 9, 0, 1, 8'hC1, 0), // R10 enqueued entry kept
    tv(1, 15, 8'hD1, 0, 0, 1, 0, 8'h00, 0), // R3 highest queue
    tv(1, 0, 8'hE1, 1, 15, 1, 1, 8'hD1, 0), // R3 lowest queue
    tv(0, 0, 8'h00, 1, 0, 0, 1, 8'hE1, 0)
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    enq_valid = 1'b0; enq_qid = '0; enq_ptr = '0;
    deq_valid = 1'b0; deq_qid = '0;
  endtask

  // drive at negedge, check enq_ok, then check registered outputs after posedge
  task automatic step(input bit ev, input logic [3:0] eq, input logic [7:0] ed,
                      input bit dv, input logic [3:0] dq, input bit xok,
                      input bit xrv, input logic [7:0] xrd, input bit xerr, input string req);
    @(negedge clk);
    enq_valid = ev; enq_qid = eq; enq_ptr = ed;
    deq_valid = dv; deq_qid = dq;
    #1;
    chk({req, " enq_ok"}, 32'(enq_ok), 32'(xok));
    @(posedge clk);
    #1;
    chk({req, " rvalid"}, 32'(deq_rvalid), 32'(xrv));
    chk({req, " err"}, 32'(deq_err), 32'(xerr));
    if (xrv) chk({req, " data"}, 32'(deq_ptr), 32'(xrd));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle();
    repeat (2) @(negedge clk);
    chk("R1 empty during reset", 32'(q_empty), 32'hFFFF);
    chk("R1 rvalid/err during reset", {30'd0, deq_rvalid, deq_err}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    total = 0; bad = 0; done = 1'b0;
    rst_n = 1'b0;
    idle();
    do_reset();
    chk("R1 empty after reset", 32'(q_empty), 32'hFFFF);
    chk("R1 full after reset", 32'(q_full), 32'h0);
    chk("R1 outputs after reset", {30'd0, deq_rvalid, deq_err}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [28:0] v;
      v = VEC[i];
      step(v[28], v[27:24], v[23:16], v[15], v[14:11], v[10], v[9], v[8:1], v[0],
           $sformatf("R2/R3/R4/R6-R10 vec%0d", i));
    end
    @(negedge clk); idle(); #1;
    chk("R5 all empty after table", 32'(q_empty), 32'hFFFF);

    // R5 / R4: fill q7, full flag, refused pointer never stored
    for (int i = 0; i < DEPTH; i++)
      step(1, 7, 8'h70 + 8'(i), 0, 0, 1, 0, 0, 0, "R5 fill q7");
    @(negedge clk); idle(); #1;
    chk("R5 q7 full only", 32'(q_full), 32'h0080);
    chk("R5 q7 not empty", 32'(q_empty), 32'hFF7F);
    step(1, 7, 8'hEE, 0, 0, 0, 0, 0, 0, "R4 refuse into full q7");
    step(1, 3, 8'h33, 0, 0, 1, 0, 0, 0, "R3 q3 unaffected by full q7");
    for (int i = 0; i < DEPTH; i++)
      step(0, 0, 0, 1, 7, 0, 1, 8'h70 + 8'(i), 0, "R4 drain q7 without refused entry");
    step(0, 0, 0, 1, 7, 0, 0, 0, 1, "R5 q7 drained");
    @(negedge clk); idle(); #1;
    chk("R3 only q3 holds data", 32'(q_empty), 32'hFFF7);

    // R1: reset taken with data present
    do_reset();
    chk("R1 empty after mid-run reset", 32'(q_empty), 32'hFFFF);
    chk("R1 full after mid-run reset", 32'(q_full), 32'h0);
    step(0, 0, 0, 1, 3, 0, 0, 0, 1, "R1 q3 cleared by reset");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule